// File: doc/BRIEF.md
# Sector Erase Command Timer

This block sits behind the bus-cycle decoder of one flash bank and gathers sector erase requests into a bitmap of pending sectors. The first accepted erase write opens an acceptance window. Further erase writes may add more sectors, in any order, while the window is open. Every write cycle that lands inside the window restarts the window's count. When the count reaches its limit with the strobe low, the block hands the gathered bitmap to the erase engine with a one-cycle launch pulse. It then stays busy until the engine reports completion.

Inside the window, a write of any command other than sector erase or erase suspend cancels the whole queued request. The block drops the bitmap and returns to read mode. Once erase has launched, the block ignores every write until the engine reports completion. An erase write that arrives after expiry is therefore rejected. An asynchronous hardware reset clears everything at once.

The window length is given in microseconds together with the clock frequency. It is rounded up to whole clock cycles, and its default is 80 µs at 100 MHz.

Top module: `sector_erase_timer`

## Requirements
- R1: While `rstN` is low and right after it rises, `pendMask` is zero and `startPulse`, `windowExpired` and `abortRead` are low.
- R2: In read mode, a write commit is a clock edge that samples `wrEn` high after one that sampled it low. A write commit with `cmdCode` equal to `ERASE_CODE` (default 8'h30) and an in-range `secIdx` sets bit `secIdx` of `pendMask` and opens the window. The bit is visible after that edge.
- R3: Within the window, each further erase commit with an in-range index ORs bit `secIdx` into `pendMask`, in any order. Repeated indices leave the mask unchanged.
- R4: `startPulse` rises after exactly TIMER_CYC consecutive clock edges that sample `wrEn` low, counted from the last edge that sampled `wrEn` high inside the window. TIMER_CYC = ceil(CLK_HZ*TIMEOUT_US/1e6). Any cycle with `wrEn` high restarts this count, including a suspend write.
- R5: `startPulse` is high for exactly one cycle, and during it `pendMask` holds every sector queued in the window. In the cycle after, `pendMask` is zero.
- R6: `windowExpired` is low in read mode and during the window. It is high from the launch cycle until the cycle after the engine reports completion with `engDone` high.
- R7: A commit inside the window whose code is neither `ERASE_CODE` nor `SUSPEND_CODE` (default 8'hB0) raises `abortRead` for one cycle. The same edge clears `pendMask` and returns the block to read mode, and no launch follows.
- R8: A suspend commit inside the window keeps the queued bits and does not abort.
- R9: From launch until `engDone`, all writes are ignored: `pendMask` stays zero, no second launch occurs and `abortRead` stays low.
- R10: In read mode, commits of any code other than `ERASE_CODE` change nothing and raise no abort.
- R11: Pulling `rstN` low clears `pendMask` and drops every status output at once, without waiting for a clock edge.
- R12: An erase commit whose `secIdx` is NUM_SECTORS or more sets no bit. In read mode it does not open the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| wrEn | input | 1 | Decoded write strobe, high while a bus write is in progress |
| cmdCode | input | 8 | Command byte of the write |
| secIdx | input | SEC_W | Sector index of the write |
| engDone | input | 1 | Erase engine finished, returns the block to read mode |
| pendMask | output | NUM_SECTORS | Pending-sector bitmap, valid with `startPulse` |
| startPulse | output | 1 | One-cycle launch request to the erase engine |
| windowExpired | output | 1 | Window has expired, erase launched or running |
| abortRead | output | 1 | One-cycle pulse: queued erase cancelled, bank back in read mode |

## Verification
Directed sequences first build a mask out of order, including a duplicate and an out-of-range index. They then measure the launch cycle against the window length, which separates an off-by-one count from a correct one. A suspend write is placed mid-window to show that a restarted count differs from a count that kept running. Foreign commands are sent in the window, in read mode and after launch, to tell abort from silent ignore and from late acceptance. A long seeded random run mixes write holds, gaps shorter and longer than the window, engine completions and resets, and compares every cycle with a reference model kept in the bench.

// File: rtl/secq_pkg.sv
package secq_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic runTimer;
    logic addSector;
    logic clrMask;
  } dpCtl_t;

endpackage

// File: rtl/secq_dpath.sv
module secq_dpath
  import secq_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4,
  parameter int TIMER_CYC   = 8000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [SEC_W-1:0]       secIdx,
  output logic [NUM_SECTORS-1:0] pendMask,
  output logic                   secValid,
  output logic                   timerDone
);
  localparam int TW = (TIMER_CYC > 1) ? $clog2(TIMER_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMER_CYC - 1);

  logic [TW-1:0]          tmr;
  logic [NUM_SECTORS-1:0] secBit;

  assign secValid  = 32'(secIdx) < NUM_SECTORS;
  assign timerDone = (tmr == LAST);

  // One-hot decode of the sector index into the bitmap
  always_comb begin
    secBit = '0;
    for (int i = 0; i < NUM_SECTORS; i++)
      if (32'(secIdx) == i) secBit[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
    end else if (ctl.clrMask) begin
      pendMask <= '0;
    end else if (ctl.addSector) begin
      pendMask <= pendMask | secBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (ctl.clrTimer) begin
      tmr <= '0;
    end else if (ctl.runTimer && !timerDone) begin
      tmr <= tmr + 1'b1;
    end
  end

  // R4: the window counter never runs past its last value
  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(tmr) < TIMER_CYC);

  // R3: without a clear, queued bits are never lost
  a_r3_mask_grows: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrMask |=> ((pendMask & $past(pendMask)) == $past(pendMask)));

endmodule

// File: rtl/secq_ctrl.sv
module secq_ctrl
  import secq_pkg::*;
#(
  parameter logic [7:0] ERASE_CODE   = 8'h30,
  parameter logic [7:0] SUSPEND_CODE = 8'hB0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] cmdCode,
  input  logic       secValid,
  input  logic       timerDone,
  input  logic       engDone,
  output dpCtl_t     ctl,
  output logic       startPulse,
  output logic       windowExpired,
  output logic       abortRead
);
  seqState_t state, nextState;
  logic wrPrev, wrEdge, isErase, isSuspend, abortNext;

  assign wrEdge    = wrEn && !wrPrev;
  assign isErase   = (cmdCode == ERASE_CODE);
  assign isSuspend = (cmdCode == SUSPEND_CODE);

  always_comb begin
    nextState = state;
    ctl       = '0;
    abortNext = 1'b0;
    case (state)
      ST_READ: begin
        if (wrEdge && isErase && secValid) begin
          ctl.addSector = 1'b1;
          ctl.clrTimer  = 1'b1;
          nextState     = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        ctl.clrTimer = wrEn;
        ctl.runTimer = !wrEn;
        if (wrEdge) begin
          if (isErase) begin
            ctl.addSector = secValid;
          end else if (!isSuspend) begin
            ctl.clrMask = 1'b1;
            abortNext   = 1'b1;
            nextState   = ST_READ;
          end
        end else if (!wrEn && timerDone) begin
          nextState = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        ctl.clrMask = 1'b1;
        nextState   = ST_RUN;
      end
      default: begin
        if (engDone) nextState = ST_READ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READ;
      wrPrev    <= 1'b0;
      abortRead <= 1'b0;
    end else begin
      state     <= nextState;
      wrPrev    <= wrEn;
      abortRead <= abortNext;
    end
  end

  assign startPulse    = (state == ST_LAUNCH);
  assign windowExpired = (state == ST_LAUNCH) || (state == ST_RUN);

  // R5: launch lasts one cycle
  a_r5_single_launch: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R7: an abort never coincides with a launch or an expired window
  a_r7_abort_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    abortRead |-> (!startPulse && !windowExpired));

  // R6: expired status holds until the engine reports completion
  a_r6_expired_hold: assert property (@(posedge clk) disable iff (!rstN)
    (windowExpired && !engDone) |=> windowExpired);

  // R4: the launch is preceded by a cycle with the strobe low
  a_r4_launch_after_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startPulse) |-> !$past(wrEn));

endmodule

// File: rtl/sector_erase_timer.sv
module sector_erase_timer
  import secq_pkg::*;
#(
  parameter int          NUM_SECTORS  = 16,
  parameter int          CLK_HZ       = 100_000_000,
  parameter int          TIMEOUT_US   = 80,
  parameter logic [7:0]  ERASE_CODE   = 8'h30,
  parameter logic [7:0]  SUSPEND_CODE = 8'hB0,
  localparam int         SEC_W        = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [7:0]             cmdCode,
  input  logic [SEC_W-1:0]       secIdx,
  input  logic                   engDone,
  output logic [NUM_SECTORS-1:0] pendMask,
  output logic                   startPulse,
  output logic                   windowExpired,
  output logic                   abortRead
);
  localparam longint unsigned CYC_L =
    (64'(CLK_HZ) * 64'(TIMEOUT_US) + 64'd999_999) / 64'd1_000_000;
  localparam int TIMER_CYC = (CYC_L < 1) ? 1 : int'(CYC_L);

  dpCtl_t ctl;
  logic   secValid, timerDone;

  secq_ctrl #(
    .ERASE_CODE  (ERASE_CODE),
    .SUSPEND_CODE(SUSPEND_CODE)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .cmdCode      (cmdCode),
    .secValid     (secValid),
    .timerDone    (timerDone),
    .engDone      (engDone),
    .ctl          (ctl),
    .startPulse   (startPulse),
    .windowExpired(windowExpired),
    .abortRead    (abortRead)
  );

  secq_dpath #(
    .NUM_SECTORS(NUM_SECTORS),
    .SEC_W      (SEC_W),
    .TIMER_CYC  (TIMER_CYC)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .secIdx   (secIdx),
    .pendMask (pendMask),
    .secValid (secValid),
    .timerDone(timerDone)
  );

  // R5: the bitmap is empty once the launch cycle is over
  a_r5_mask_cleared: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (pendMask == '0));

  // R9: while erase runs nothing is queued
  a_r9_run_empty: assert property (@(posedge clk) disable iff (!rstN)
    (windowExpired && !startPulse) |-> (pendMask == '0));

endmodule

// File: tb/sector_erase_timer_test.sv
module sector_erase_timer_test;
  localparam int NS = 12;
  localparam int SW = $clog2(NS);
  localparam int T  = 20;          // 250 kHz * 80 us
  localparam logic [7:0] ER = 8'h30, SU = 8'hB0;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, engDone = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic [SW-1:0] secIdx = '0;
  logic [NS-1:0] pendMask;
  logic startPulse, windowExpired, abortRead;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  sector_erase_timer #(.NUM_SECTORS(NS), .CLK_HZ(250_000), .TIMEOUT_US(80)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdCode(cmdCode), .secIdx(secIdx),
    .engDone(engDone), .pendMask(pendMask), .startPulse(startPulse),
    .windowExpired(windowExpired), .abortRead(abortRead));

  // Reference model from the requirements
  int mSt = 0, mCnt = 0;
  logic [NS-1:0] mMask = '0;
  logic mAbort = 1'b0, mPrev = 1'b0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mMask = '0; mAbort = 1'b0; mPrev = 1'b0;
    end else begin
      logic edgeW;
      edgeW = wrEn && !mPrev;
      mPrev = wrEn;
      mAbort = 1'b0;
      case (mSt)
        0: if (edgeW && cmdCode == ER && int'(secIdx) < NS) begin
             mMask = mMask | (NS'(1) << secIdx); mSt = 1; mCnt = 0;
           end
        1: begin
             if (edgeW) begin
               mCnt = 0;
               if (cmdCode == ER) begin
                 if (int'(secIdx) < NS) mMask = mMask | (NS'(1) << secIdx);
               end else if (cmdCode != SU) begin
                 mMask = '0; mAbort = 1'b1; mSt = 0;
               end
             end else if (wrEn) mCnt = 0;
             else begin
               mCnt = mCnt + 1;
               if (mCnt == T) mSt = 2;
             end
           end
        2: begin mSt = 3; mMask = '0; end
        default: if (engDone) mSt = 0;
      endcase
    end
  end

  function automatic logic [NS+2:0] expOut();
    return {mMask, mSt == 2, mSt >= 2, mAbort};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [NS+2:0] got;
    @(posedge clk);
    @(negedge clk);
    got = {pendMask, startPulse, windowExpired, abortRead};
    nChk++;
    if (got !== expOut()) begin
      nBad++;
      $display("FAIL model R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 actual %h expected %h",
               got, expOut());
    end
  endtask

  task automatic wr(logic [7:0] c, int s, int hold);
    wrEn = 1'b1; cmdCode = c; secIdx = SW'(s);
    repeat (hold) tick();
    wrEn = 1'b0;
    tick();
  endtask

  task automatic waitStart(output int n);
    n = 0;
    while (!startPulse && n < 100) begin tick(); n++; end
  endtask

  task automatic quiet(int n, output int seen);
    seen = 0;
    repeat (n) begin tick(); if (startPulse) seen++; end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog expired actual hung expected done");
    finishRun();
  end

  initial begin
    int n, seen;
    void'($urandom(32'd4242));
    repeat (3) tick();
    chk("R1 mask in reset", 32'(pendMask), 0);
    rstN = 1'b1;
    tick();
    chk("R1 status after reset", {startPulse, windowExpired, abortRead}, 0);

    wr(ER, 3, 1);
    chk("R2 first sector", 32'(pendMask), 32'h008);
    wr(ER, 9, 2); wr(ER, 0, 1); wr(ER, 3, 1);
    chk("R3 out-of-order add", 32'(pendMask), 32'h209);
    wr(ER, 13, 1);
    chk("R12 out of range in window", 32'(pendMask), 32'h209);
    chk("R6 low in window", 32'(windowExpired), 0);
    waitStart(n);
    chk("R4 launch cycle", n, T - 1);
    chk("R5 mask at launch", 32'(pendMask), 32'h209);
    chk("R6 expired at launch", 32'(windowExpired), 1);
    tick();
    chk("R5 pulse width", 32'(startPulse), 0);
    chk("R5 mask cleared", 32'(pendMask), 0);

    wr(ER, 5, 1);
    chk("R9 erase after expiry", 32'(pendMask), 0);
    wr(8'hF0, 2, 1);
    chk("R9 no abort while running", 32'(abortRead), 0);
    quiet(T + 5, seen);
    chk("R9 no second launch", seen, 0);
    engDone = 1'b1; tick(); engDone = 1'b0; tick();
    chk("R6 cleared after done", 32'(windowExpired), 0);

    wr(8'hF0, 2, 1);
    chk("R10 idle foreign cmd", {pendMask, abortRead}, 0);
    wr(ER, 14, 1);
    quiet(T + 5, seen);
    chk("R12 idle out of range", {pendMask, 1'(seen != 0)}, 0);

    wr(ER, 1, 1);
    repeat (8) tick();
    wr(SU, 0, 1);
    chk("R8 suspend keeps mask", {pendMask, abortRead}, 32'h2 << 1);
    waitStart(n);
    chk("R4 restart on suspend", n, T - 1);
    tick(); engDone = 1'b1; tick(); engDone = 1'b0;

    wr(ER, 4, 1);
    repeat (3) tick();
    wrEn = 1'b1; cmdCode = 8'h90; tick(); wrEn = 1'b0;
    chk("R7 abort pulse and clear", {pendMask, abortRead}, 1);
    tick();
    chk("R7 abort one cycle", 32'(abortRead), 0);
    quiet(T + 5, seen);
    chk("R7 no launch after abort", seen, 0);

    wr(ER, 6, 1);
    rstN = 1'b0; #1;
    chk("R11 async reset", {pendMask, windowExpired, startPulse}, 0);
    tick(); rstN = 1'b1; tick();

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      engDone = ($urandom_range(0, 9) == 0);
      if (r < 1) begin
        rstN = 1'b0; tick(); rstN = 1'b1; tick();
      end else if (r < 30) begin
        int k;
        k = $urandom_range(0, 9);
        wr(k < 6 ? ER : (k < 8 ? SU : 8'($urandom_range(0, 255))),
           $urandom_range(0, 15), $urandom_range(1, 3));
      end else begin
        repeat ($urandom_range(0, 30)) tick();
      end
    end
    finishRun();
  end
endmodule